// File: doc/BRIEF.md
# Isochronous Cycle Timer with Bus-Time Extension

This block keeps the free-running bus cycle timer of an isochronous serial bus node. A tick enable at 24.576 MHz advances a sub-cycle offset. Each time the offset wraps, a cycle counter advances. Each time the cycle counter wraps, a 7-bit seconds counter advances. All three fields are packed into one 32-bit word, and software can read or write that word through a small register port.

A second register stretches the 7-bit seconds field into a 32-bit bus-time value. It stores its own upper 25 bits together with a shadow copy of seconds bit 6. Whenever the live bit 6 differs from the shadow, 0x40 is added to the stored value. Because of this, the upper part carries exactly once on every 128-second wrap. A read applies that correction in the same cycle, so a read taken just after a wrap returns the right value even before the correction has been written back.

Two sticky event flags report conditions to the rest of the chip. One marks each 64-second boundary. The other marks a software overwrite of the timer, which breaks cycle consistency. Each flag is cleared by a write-one-to-clear input. An initialisation strobe seeds the seconds field and bus time from an external seconds count.

Top module: `iso_cycle_clock`

## Requirements
- R1: After reset, the cycle-time word, the bus-time value and both event flags are all zero.
- R2: Each cycle with `tick_en` high advances the offset (bits 11:0) by one. An offset of 3071 or more returns to 0 and advances the cycle count. Without a tick, write or init, the timer holds its value.
- R3: A cycle count of 7999 or more returns to 0 on an offset wrap and advances the seconds field. The seconds field rolls from 127 to 0.
- R4: With `reg_sel`=0, `reg_rdata` shows the cycle-time word: seconds in bits 31:25, cycle count in bits 24:12, offset in bits 11:0. With `reg_sel`=1 it shows bus time.
- R5: A register write with `reg_sel`=0 loads all three fields from `reg_wdata` on the next edge, in place of any tick, and sets the inconsistent flag (`ev_inconsistent`).
- R6: Bus time equals the stored upper bits 31:7 ORed with the live seconds field. Each time seconds bit 6 falls, whether by counting or by a write, bits 31:7 increase by one. A read shows this in the very cycle the new seconds value appears.
- R7: A register write with `reg_sel`=1 replaces bus-time bits 31:7 only. Bits 6:0 keep following the seconds field.
- R8: `ev_sec64` is set when counting changes seconds bit 6, in either direction. A write that changes bit 6 does not set it.
- R9: Flags stay set until cleared. `ev_clear[0]` clears `ev_sec64` and `ev_clear[1]` clears `ev_inconsistent`. A set and a clear in the same cycle leave the flag set.
- R10: `init_load` overrides any write and tick in that cycle. It loads seconds from `init_secs[6:0]` and zeroes the count and offset. It loads bus time with `init_secs` with bits 5:0 cleared. It does not set the inconsistent flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | 24.576 MHz timer tick enable |
| init_load | input | 1 | Initialisation strobe |
| init_secs | input | 32 | External seconds count used by init_load |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects cycle time, 1 selects bus time |
| reg_wdata | input | 32 | Register write data |
| ev_clear | input | 2 | Write-one-to-clear for the event flags |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| ev_sec64 | output | 1 | Sticky 64-second event |
| ev_inconsistent | output | 1 | Sticky cycle-inconsistent event |

## Verification
The timer is driven with isolated ticks, with a preloaded state just below each wrap point, and with a long run of random ticks. This separates the offset step, the count carry and the seconds carry. Writes that move seconds bit 6 up and down, with no tick, separate the write-driven bus-time carry from the 64-second event, which must fire only when counting moves that bit. Reads of bus time in the very cycle the seconds wrap show whether the same-cycle correction is present. An init strobe given together with a write and a tick shows the override order.

// File: rtl/cyc_pkg.sv
// Shared constants for the isochronous cycle timer.
// Assumes a 32-bit register word and two event flags.
package cyc_pkg;
    localparam int BUS_W     = 32;
    localparam int NUM_EV    = 2;
    localparam int EV_SEC64  = 0;
    localparam int EV_INCONS = 1;

    typedef enum logic {
        SEL_CYCLE = 1'b0,
        SEL_BUS   = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/cyc_counter.sv
// Three-field cycle counter: offset, cycle count and seconds.
// It advances on a tick enable and can be loaded in one cycle; a load wins over a tick.
// Assumes that the limits fit in their field widths. Out-of-range values wrap on the next carry.
module cyc_counter #(
    parameter int OFF_W   = 12,
    parameter int CNT_W   = 13,
    parameter int SEC_W   = 7,
    parameter int OFF_LIM = 3072,
    parameter int CNT_LIM = 8000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             load_en,
    input  logic [OFF_W-1:0] load_off,
    input  logic [CNT_W-1:0] load_cnt,
    input  logic [SEC_W-1:0] load_sec,
    output logic [OFF_W-1:0] off_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic [SEC_W-1:0] sec_q,
    output logic             half_flip
);
    localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(OFF_LIM - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CNT_LIM - 1);

    logic off_last;
    logic cnt_last;
    logic sec_roll;

    // Detect the carry chain and a counting change of the seconds top bit.
    always_comb begin
        off_last  = (off_q >= OFF_LAST);
        cnt_last  = (cnt_q >= CNT_LAST);
        sec_roll  = tick_en && off_last && cnt_last && !load_en;
        half_flip = sec_roll && (&sec_q[SEC_W-2:0]);
    end

    // Advance or load the three fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q <= '0;
            cnt_q <= '0;
            sec_q <= '0;
        end else if (load_en) begin
            off_q <= load_off;
            cnt_q <= load_cnt;
            sec_q <= load_sec;
        end else if (tick_en) begin
            if (off_last) begin
                off_q <= '0;
                if (cnt_last) begin
                    cnt_q <= '0;
                    sec_q <= sec_q + 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                off_q <= off_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/bus_time_ext.sv
// Widens the seconds field into a full bus-time word.
// It stores the upper bits and a shadow of the seconds top bit, and adds one top-bit step whenever the shadow differs from the live bit.
// Assumes the seconds field changes at most once per clock.
module bus_time_ext #(
    parameter int BUS_W = 32,
    parameter int SEC_W = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [SEC_W-1:0]       sec_now,
    input  logic                   init_en,
    input  logic [BUS_W-1:0]       init_val,
    input  logic                   wr_en,
    input  logic [BUS_W-1:SEC_W]   wr_hi,
    output logic [BUS_W-1:0]       bus_now
);
    localparam int              MARK     = SEC_W - 1;
    localparam logic [BUS_W-1:0] STEP     = BUS_W'(1) << MARK;
    localparam logic [BUS_W-1:0] LOW_MASK = STEP - 1'b1;

    logic [BUS_W-1:0] base_q;
    logic [BUS_W-1:0] fixed;

    // Correct the stored value against the live top bit, then merge in the seconds.
    always_comb begin
        fixed   = (base_q[MARK] != sec_now[MARK]) ? base_q + STEP : base_q;
        bus_now = fixed | {{(BUS_W-SEC_W){1'b0}}, sec_now};
    end

    // Hold the corrected value; init and software writes take their share.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (init_en) begin
            base_q <= init_val & ~LOW_MASK;
        end else if (wr_en) begin
            base_q <= {wr_hi, fixed[SEC_W-1:0]};
        end else begin
            base_q <= fixed;
        end
    end
endmodule

// File: rtl/event_flags.sv
// Bank of sticky event flags with write-one-to-clear; a set beats a clear in the same cycle.
module event_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_in,
    input  logic [N-1:0] clr_in,
    output logic [N-1:0] flag_q
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // One sticky flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q[i] <= 1'b0;
            end else if (set_in[i]) begin
                flag_q[i] <= 1'b1;
            end else if (clr_in[i]) begin
                flag_q[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/iso_cycle_clock.sv
// Top of the isochronous cycle timer.
// It joins the cycle counter, the bus-time extension and the event flags behind a one-word register port.
// Assumes the field widths add up to the bus word. Reads are combinational.
module iso_cycle_clock
    import cyc_pkg::*;
#(
    parameter int OFF_W   = 12,
    parameter int CNT_W   = 13,
    parameter int OFF_LIM = 3072,
    parameter int CNT_LIM = 8000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_en,
    input  logic        init_load,
    input  logic [31:0] init_secs,
    input  logic        reg_wr,
    input  logic        reg_sel,
    input  logic [31:0] reg_wdata,
    input  logic [1:0]  ev_clear,
    output logic [31:0] reg_rdata,
    output logic        ev_sec64,
    output logic        ev_inconsistent
);
    localparam int SEC_W  = BUS_W - OFF_W - CNT_W;
    localparam int CNT_LO = OFF_W;
    localparam int SEC_LO = OFF_W + CNT_W;

    logic              cyc_wr;
    logic              bus_wr;
    logic              load_en;
    logic [OFF_W-1:0]  load_off;
    logic [CNT_W-1:0]  load_cnt;
    logic [SEC_W-1:0]  load_sec;
    logic [OFF_W-1:0]  off_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [SEC_W-1:0]  sec_q;
    logic              half_flip;
    logic [BUS_W-1:0]  cyc_now;
    logic [BUS_W-1:0]  bus_now;
    logic [NUM_EV-1:0] ev_set;
    logic [NUM_EV-1:0] ev_q;

    // Decode the register port; init overrides every write.
    always_comb begin
        cyc_wr  = reg_wr && (reg_sel_e'(reg_sel) == SEL_CYCLE) && !init_load;
        bus_wr  = reg_wr && (reg_sel_e'(reg_sel) == SEL_BUS) && !init_load;
        load_en = init_load || cyc_wr;
        if (init_load) begin
            load_off = '0;
            load_cnt = '0;
            load_sec = init_secs[SEC_W-1:0];
        end else begin
            load_off = reg_wdata[CNT_LO-1:0];
            load_cnt = reg_wdata[SEC_LO-1:CNT_LO];
            load_sec = reg_wdata[BUS_W-1:SEC_LO];
        end
    end

    cyc_counter #(
        .OFF_W  (OFF_W),
        .CNT_W  (CNT_W),
        .SEC_W  (SEC_W),
        .OFF_LIM(OFF_LIM),
        .CNT_LIM(CNT_LIM)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .load_en  (load_en),
        .load_off (load_off),
        .load_cnt (load_cnt),
        .load_sec (load_sec),
        .off_q    (off_q),
        .cnt_q    (cnt_q),
        .sec_q    (sec_q),
        .half_flip(half_flip)
    );

    bus_time_ext #(
        .BUS_W(BUS_W),
        .SEC_W(SEC_W)
    ) u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .sec_now (sec_q),
        .init_en (init_load),
        .init_val(init_secs),
        .wr_en   (bus_wr),
        .wr_hi   (reg_wdata[BUS_W-1:SEC_W]),
        .bus_now (bus_now)
    );

    // Gather event causes and pack the timer word.
    always_comb begin
        ev_set            = '0;
        ev_set[EV_SEC64]  = half_flip;
        ev_set[EV_INCONS] = cyc_wr;
        cyc_now           = {sec_q, cnt_q, off_q};
    end

    event_flags #(
        .N(NUM_EV)
    ) u_ev (
        .clk   (clk),
        .rst_n (rst_n),
        .set_in(ev_set),
        .clr_in(ev_clear),
        .flag_q(ev_q)
    );

    // Drive the read mux and the flag outputs.
    always_comb begin
        reg_rdata       = (reg_sel_e'(reg_sel) == SEL_BUS) ? bus_now : cyc_now;
        ev_sec64        = ev_q[EV_SEC64];
        ev_inconsistent = ev_q[EV_INCONS];
    end
endmodule

// File: rtl/iso_cycle_clock_chk.sv
// Property checker for iso_cycle_clock, attached with bind.
module iso_cycle_clock_chk #(
    parameter int OFF_W   = 12,
    parameter int CNT_W   = 13,
    parameter int OFF_LIM = 3072,
    parameter int SEC_W   = 7
) (
    input logic        clk,
    input logic        rst_n,
    input logic        tick_en,
    input logic        init_load,
    input logic [31:0] init_secs,
    input logic        reg_wr,
    input logic        reg_sel,
    input logic [31:0] reg_wdata,
    input logic [1:0]  ev_clear,
    input logic        ev_sec64,
    input logic        ev_inconsistent,
    input logic [31:0] cyc_now,
    input logic [31:0] bus_now
);
    logic quiet;
    logic cyc_write;
    logic bus_write;
    assign quiet     = !tick_en && !reg_wr && !init_load;
    assign cyc_write = reg_wr && !reg_sel && !init_load;
    assign bus_write = reg_wr && reg_sel && !init_load;

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |=> $stable(cyc_now));

    // R2
    off_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !reg_wr && !init_load && (cyc_now[OFF_W-1:0] < OFF_W'(OFF_LIM - 1)))
        |=> (cyc_now[OFF_W-1:0] == $past(cyc_now[OFF_W-1:0]) + 1'b1));

    // R5
    cyc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_write |=> (cyc_now == $past(reg_wdata)) && ev_inconsistent);

    // R6
    bus_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_now[SEC_W-1:0] == cyc_now[31:32-SEC_W]);

    // R7
    bus_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_write && !tick_en) |=> (bus_now[31:SEC_W] == $past(reg_wdata[31:SEC_W])));

    // R9
    clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_clear[1] && !cyc_write) |=> !ev_inconsistent);

    // R8
    sec64_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ev_sec64) |-> $past(tick_en && !init_load && !(reg_wr && !reg_sel)));

    // R10
    init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_load |=> (cyc_now == {$past(init_secs[SEC_W-1:0]), {(32-SEC_W){1'b0}}})
                      && (bus_now == $past(init_secs)));
endmodule

bind iso_cycle_clock iso_cycle_clock_chk #(
    .OFF_W  (OFF_W),
    .CNT_W  (CNT_W),
    .OFF_LIM(OFF_LIM),
    .SEC_W  (SEC_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .tick_en        (tick_en),
    .init_load      (init_load),
    .init_secs      (init_secs),
    .reg_wr         (reg_wr),
    .reg_sel        (reg_sel),
    .reg_wdata      (reg_wdata),
    .ev_clear       (ev_clear),
    .ev_sec64       (ev_sec64),
    .ev_inconsistent(ev_inconsistent),
    .cyc_now        (cyc_now),
    .bus_now        (bus_now)
);

// File: tb/sim_iso_cycle_clock.sv
module sim_iso_cycle_clock;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        init_load = 1'b0;
    logic [31:0] init_secs = '0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [1:0]  ev_clear = '0;
    logic [31:0] reg_rdata;
    logic        ev_sec64;
    logic        ev_inconsistent;

    int    errors = 0;
    int    checks = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // Behavioural reference state
    logic [11:0] m_off = '0;
    logic [12:0] m_cnt = '0;
    logic [6:0]  m_sec = '0;
    logic [24:0] m_hi = '0;
    logic        m_b6 = 1'b0;
    logic        m_e64 = 1'b0;
    logic        m_einc = 1'b0;

    always #4 clk = ~clk;

    iso_cycle_clock u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .init_load(init_load),
        .init_secs(init_secs), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .ev_clear(ev_clear), .reg_rdata(reg_rdata),
        .ev_sec64(ev_sec64), .ev_inconsistent(ev_inconsistent)
    );

    // Reference model, advanced on each rising edge.
    always @(posedge clk) begin
        bit s64, sinc;
        logic old6;
        s64 = 0; sinc = 0;
        if (!rst_n) begin
            m_off = '0; m_cnt = '0; m_sec = '0; m_hi = '0; m_b6 = 0;
            m_e64 = 0; m_einc = 0;
        end else begin
            if (init_load) begin
                m_off = '0; m_cnt = '0; m_sec = init_secs[6:0];
                m_hi = init_secs[31:7]; m_b6 = init_secs[6];
            end else begin
                if (reg_wr && reg_sel) m_hi = reg_wdata[31:7];
                if (reg_wr && !reg_sel) begin
                    m_sec = reg_wdata[31:25]; m_cnt = reg_wdata[24:12];
                    m_off = reg_wdata[11:0]; sinc = 1;
                end else if (tick_en) begin
                    old6 = m_sec[6];
                    if (m_off >= 12'd3071) begin
                        m_off = '0;
                        if (m_cnt >= 13'd7999) begin
                            m_cnt = '0; m_sec = m_sec + 7'd1;
                        end else m_cnt = m_cnt + 13'd1;
                    end else m_off = m_off + 12'd1;
                    if (m_sec[6] != old6) s64 = 1;
                end
                if (m_b6 != m_sec[6]) {m_hi, m_b6} = {m_hi, m_b6} + 26'd1;
            end
            m_e64  = s64  | (m_e64  & !ev_clear[0]);
            m_einc = sinc | (m_einc & !ev_clear[1]);
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Compare the ports with the model; called at a falling edge.
    task automatic compare();
        logic [31:0] exp;
        exp = reg_sel ? {m_hi, m_sec} : {m_sec, m_cnt, m_off};
        chk(reg_rdata === exp, cur_req, reg_rdata, exp);
        chk(ev_sec64 === m_e64, {cur_req, " ev_sec64"}, {31'd0, ev_sec64}, {31'd0, m_e64});
        chk(ev_inconsistent === m_einc, {cur_req, " ev_inconsistent"},
            {31'd0, ev_inconsistent}, {31'd0, m_einc});
    endtask

    // Apply one cycle of inputs, let one edge pass, then compare.
    task automatic drive(input bit tk, input bit wr, input bit sel, input logic [31:0] wd,
                         input logic [1:0] clr, input bit ini, input logic [31:0] iv);
        tick_en = tk; reg_wr = wr; reg_sel = sel; reg_wdata = wd;
        ev_clear = clr; init_load = ini; init_secs = iv;
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        cur_req = "R1";
        drive(0, 0, 0, 0, 0, 0, 0);
        chk(reg_rdata === 32'h0, "R1 cycle", reg_rdata, 32'h0);
        drive(0, 0, 1, 0, 0, 0, 0);
        chk(reg_rdata === 32'h0, "R1 bus", reg_rdata, 32'h0);
        chk({ev_sec64, ev_inconsistent} === 2'b00, "R1 flags", {30'd0, ev_sec64, ev_inconsistent}, 0);

        // R2 ticks with gaps
        cur_req = "R2";
        for (int i = 0; i < 5; i++) begin
            drive(1, 0, 0, 0, 0, 0, 0);
            drive(0, 0, 0, 0, 0, 0, 0);
        end
        chk(reg_rdata === 32'd5, "R2 offset", reg_rdata, 32'd5);

        // R5 write, then R2/R3 carries to seconds 64 and R8 event
        cur_req = "R5";
        drive(1, 1, 0, 32'h7FF3FBFE, 0, 0, 0);
        chk(reg_rdata === 32'h7FF3FBFE, "R5 load", reg_rdata, 32'h7FF3FBFE);
        chk(ev_inconsistent === 1'b1, "R5 flag", {31'd0, ev_inconsistent}, 1);
        cur_req = "R3";
        drive(1, 0, 0, 0, 0, 0, 0);
        chk(reg_rdata === 32'h7FF3FBFF, "R2 offset last", reg_rdata, 32'h7FF3FBFF);
        drive(1, 0, 1, 0, 0, 0, 0);
        chk(reg_rdata === 32'h00000040, "R6 bus at 64", reg_rdata, 32'h40);
        drive(0, 0, 0, 0, 0, 0, 0);
        chk(reg_rdata === 32'h80000000, "R4 fields", reg_rdata, 32'h80000000);
        chk(ev_sec64 === 1'b1, "R8 sec64 set", {31'd0, ev_sec64}, 1);

        // R9 clears, then set beats clear
        cur_req = "R9";
        drive(0, 0, 0, 0, 2'b11, 0, 0);
        chk({ev_sec64, ev_inconsistent} === 2'b00, "R9 cleared", {30'd0, ev_sec64, ev_inconsistent}, 0);
        drive(0, 1, 0, 32'hFFF3FBFF, 2'b10, 0, 0);
        chk(ev_inconsistent === 1'b1, "R9 set wins", {31'd0, ev_inconsistent}, 1);

        // R6 wrap 127 -> 0 carries into upper bits, seen in the same cycle
        cur_req = "R6";
        drive(1, 0, 1, 0, 0, 0, 0);
        chk(reg_rdata === 32'h00000080, "R6 carry", reg_rdata, 32'h80);
        chk(ev_sec64 === 1'b1, "R8 falling bit", {31'd0, ev_sec64}, 1);
        drive(0, 0, 0, 0, 2'b11, 0, 0);
        chk(reg_rdata === 32'h0, "R3 seconds roll", reg_rdata, 32'h0);

        // R7 bus write, then write-driven bit 6 moves (no R8 event)
        cur_req = "R7";
        drive(0, 1, 1, 32'hABCDEF55, 0, 0, 0);
        chk(reg_rdata === 32'hABCDEF00, "R7 upper only", reg_rdata, 32'hABCDEF00);
        drive(0, 1, 0, 32'h8A000000, 0, 0, 0);
        drive(0, 0, 1, 0, 0, 0, 0);
        chk(reg_rdata === 32'hABCDEF45, "R7 low follows", reg_rdata, 32'hABCDEF45);
        cur_req = "R8";
        drive(0, 1, 0, 32'h06000000, 0, 0, 0);
        drive(0, 0, 1, 0, 0, 0, 0);
        chk(reg_rdata === 32'hABCDEF83, "R6 write carry", reg_rdata, 32'hABCDEF83);
        chk(ev_sec64 === 1'b0, "R8 no event on write", {31'd0, ev_sec64}, 0);

        // R10 init overrides write and tick
        cur_req = "R10";
        drive(0, 0, 0, 0, 2'b11, 0, 0);
        drive(1, 1, 0, 32'hFFFFFFFF, 0, 1, 32'h12345678);
        chk(reg_rdata === 32'hF0000000, "R10 cycle", reg_rdata, 32'hF0000000);
        chk(ev_inconsistent === 1'b0, "R10 no flag", {31'd0, ev_inconsistent}, 0);
        drive(0, 0, 1, 0, 0, 0, 0);
        chk(reg_rdata === 32'h12345678, "R10 bus", reg_rdata, 32'h12345678);

        // R2 random run with occasional writes and clears
        cur_req = "R2";
        for (int i = 0; i < 20000; i++) begin
            bit wr;
            wr = ($urandom % 500) == 0;
            drive(1'($urandom), wr, 1'($urandom), $urandom,
                  (($urandom % 100) == 0) ? 2'b11 : 2'b00, 0, 0);
        end

        done = 1'b1;
        finish_run();
    end
endmodule